// File: doc/BRIEF.md
# Unlock-Protected Flash Command Sequencer

This block sits on the device side of a byte-wide NOR flash and turns a stream of decoded host write cycles into array operations. Each host write arrives as a one-cycle `wr_valid` pulse with its address and data byte. The sequencer tracks the two-write unlock handshake and the command byte that follows it. When a sequence completes, it issues a single-cycle start pulse with an operation type and a latched target address and data byte. The array controller that performs the program or erase is outside this block.

The same unlock handshake switches the read path into an identification mode or a query mode. In identification mode the block supplies the manufacturer and device bytes itself. The query table is outside this block. Both modes are left with a one-write exit command or with an unlocked exit. A write that breaks a sequence drops all progress. While the array reports busy, every write is discarded.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset `rd_mode` is 0 (array), `op_start` is 0, and `op_type`, `op_addr` and `op_data` are all zero.
- R2: The writes AAh@5555h, 55h@2AAAh and A0h@5555h followed by a fourth write (A, D) pulse `op_start` in the cycle after the fourth write. With that pulse `op_type` is 0 (program), `op_addr` is A and `op_data` is D.
- R3: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and 10h@5555h start a chip erase. `op_type` is 3, `op_addr` is 0 and `op_data` is FFh.
- R4: The same five-write prefix followed by 30h at address A starts a sector erase. `op_type` is 1 and `op_addr` keeps A[19:12] with bits 11..0 cleared. `op_data` is FFh.
- R5: The same prefix followed by 50h at address A starts a block erase. `op_type` is 2 and `op_addr` keeps A[19:16] with bits 15..0 cleared. `op_data` is FFh.
- R6: Sequence addresses are matched on bits 14..0 only. Higher bits may take any value, and a difference in bit 14 breaks the match.
- R7: AAh@5555h, 55h@2AAAh, 90h@5555h sets `rd_mode` to 1 (identification). In that mode `id_byte` is BFh for `rd_addr` 0, D8h for `rd_addr` 1, and 00h for any other address. In any other mode `id_byte` is 00h.
- R8: AAh@5555h, 55h@2AAAh, 98h@5555h sets `rd_mode` to 2 (query). `rd_mode` never takes the value 3.
- R9: In mode 1 or 2, either of two exits returns `rd_mode` to 0. One is a single F0h write to any address while no unlock is in progress. The other is AAh@5555h, 55h@2AAAh, F0h@5555h. Every other write in those modes leaves the mode unchanged and starts no operation.
- R10: A write that does not match the next expected address/data pair discards all progress. A later completion of the broken sequence starts nothing, while a fresh full sequence works.
- R11: Writes presented while `busy` is 1 are ignored, including exit commands. They change neither the mode, nor the sequence progress, nor the outputs.
- R12: `op_start` lasts exactly one cycle. `op_type`, `op_addr` and `op_data` hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One-cycle pulse marking a host write |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 8 | Host write data byte |
| busy | input | 1 | Array operation in progress |
| rd_addr | input | ADDR_W | Host read address for the identification bytes |
| op_start | output | 1 | Single-cycle operation launch |
| op_type | output | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| op_addr | output | ADDR_W | Latched target address |
| op_data | output | 8 | Latched program byte (FFh for erases) |
| rd_mode | output | 2 | 0 array, 1 identification, 2 query |
| id_byte | output | 8 | Identification byte for `rd_addr` |

## Verification
The hardest case to reach from the ports is an erase sequence broken at its fourth or fifth write. Such a sequence must afterwards ignore a valid-looking erase code, and a random stream almost never gets that far. The stimulus therefore emits whole scripted sequences and corrupts a randomly chosen byte of them at a fixed rate. It also raises `busy` part-way through some sequences, so that progress must survive the writes that are discarded. Directed cases then cover the high-address aliasing, the bit-14 mismatch and the exits from identification and query mode.

// File: rtl/nor_cmd_seq_pkg.sv
package nor_cmd_seq_pkg;

  localparam int CMP_W = 15;
  localparam logic [CMP_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMP_W-1:0] KEY_ADDR_B = 15'h2AAA;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM, SQ_E1, SQ_E2, SQ_E3
  } seq_t;

  typedef enum logic [1:0] {
    MD_ARRAY = 2'd0, MD_ID = 2'd1, MD_QRY = 2'd2
  } mode_t;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0, OP_SECT = 2'd1, OP_BLK = 2'd2, OP_CHIP = 2'd3
  } op_t;

  typedef enum logic [3:0] {
    CM_AA, CM_55, CM_A0, CM_80, CM_90, CM_98, CM_F0,
    CM_10, CM_30, CM_50, CM_NONE
  } cmd_t;

  typedef struct packed {
    logic at_a;
    logic at_b;
    cmd_t cmd;
  } wr_dec_t;

endpackage

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
  import nor_cmd_seq_pkg::*;
(
  input  logic [CMP_W-1:0] addr_lo,
  input  logic [7:0]       data,
  output wr_dec_t          dec
);

  always_comb begin
    dec.at_a = (addr_lo == KEY_ADDR_A);
    dec.at_b = (addr_lo == KEY_ADDR_B);
    unique case (data)
      8'hAA:   dec.cmd = CM_AA;
      8'h55:   dec.cmd = CM_55;
      8'hA0:   dec.cmd = CM_A0;
      8'h80:   dec.cmd = CM_80;
      8'h90:   dec.cmd = CM_90;
      8'h98:   dec.cmd = CM_98;
      8'hF0:   dec.cmd = CM_F0;
      8'h10:   dec.cmd = CM_10;
      8'h30:   dec.cmd = CM_30;
      8'h50:   dec.cmd = CM_50;
      default: dec.cmd = CM_NONE;
    endcase
  end

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_valid,
  input  logic    busy,
  input  wr_dec_t dec,
  output logic    go,
  output op_t     go_type,
  output mode_t   mode
);

  seq_t  seq_q, seq_d;
  mode_t mode_q, mode_d;
  logic  accept;

  assign accept = wr_valid && !busy;
  assign mode   = mode_q;

  always_comb begin
    seq_d   = seq_q;
    mode_d  = mode_q;
    go      = 1'b0;
    go_type = OP_PROG;
    if (accept) begin
      unique case (seq_q)
        SQ_IDLE: begin
          if (mode_q != MD_ARRAY && dec.cmd == CM_F0) mode_d = MD_ARRAY;
          else if (dec.at_a && dec.cmd == CM_AA)      seq_d  = SQ_U1;
        end
        SQ_U1: seq_d = (dec.at_b && dec.cmd == CM_55) ? SQ_U2 : SQ_IDLE;
        SQ_U2: begin
          seq_d = SQ_IDLE;
          if (dec.at_a) begin
            if (mode_q == MD_ARRAY) begin
              unique case (dec.cmd)
                CM_A0:   seq_d  = SQ_PGM;
                CM_80:   seq_d  = SQ_E1;
                CM_90:   mode_d = MD_ID;
                CM_98:   mode_d = MD_QRY;
                default: seq_d  = SQ_IDLE;
              endcase
            end else if (dec.cmd == CM_F0) begin
              mode_d = MD_ARRAY;
            end
          end
        end
        SQ_PGM: begin
          seq_d   = SQ_IDLE;
          go      = 1'b1;
          go_type = OP_PROG;
        end
        SQ_E1: seq_d = (dec.at_a && dec.cmd == CM_AA) ? SQ_E2 : SQ_IDLE;
        SQ_E2: seq_d = (dec.at_b && dec.cmd == CM_55) ? SQ_E3 : SQ_IDLE;
        SQ_E3: begin
          seq_d = SQ_IDLE;
          if (dec.at_a && dec.cmd == CM_10) begin
            go = 1'b1; go_type = OP_CHIP;
          end else if (dec.cmd == CM_30) begin
            go = 1'b1; go_type = OP_SECT;
          end else if (dec.cmd == CM_50) begin
            go = 1'b1; go_type = OP_BLK;
          end
        end
        default: seq_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= SQ_IDLE;
      mode_q <= MD_ARRAY;
    end else if (accept) begin
      seq_q  <= seq_d;
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/nor_cmd_oplatch.sv
module nor_cmd_oplatch
  import nor_cmd_seq_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int SECT_LSB = 12,
  parameter int BLK_LSB  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  op_t               go_type,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              op_start,
  output logic [1:0]        op_type,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);

  localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECT_LSB;
  localparam logic [ADDR_W-1:0] BLK_MASK  = {ADDR_W{1'b1}} << BLK_LSB;
  localparam logic [7:0]        ERASED    = 8'hFF;

  logic [ADDR_W-1:0] addr_d;
  logic [7:0]        data_d;

  always_comb begin
    unique case (go_type)
      OP_PROG: begin addr_d = addr;             data_d = data;   end
      OP_SECT: begin addr_d = addr & SECT_MASK; data_d = ERASED; end
      OP_BLK:  begin addr_d = addr & BLK_MASK;  data_d = ERASED; end
      default: begin addr_d = '0;               data_d = ERASED; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_start <= 1'b0;
    else        op_start <= go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_type <= '0;
      op_addr <= '0;
      op_data <= '0;
    end else if (go) begin
      op_type <= go_type;
      op_addr <= addr_d;
      op_data <= data_d;
    end
  end

endmodule

// File: rtl/nor_cmd_idmux.sv
module nor_cmd_idmux
  import nor_cmd_seq_pkg::*;
#(
  parameter int         ADDR_W = 20,
  parameter logic [7:0] MFR_ID = 8'hBF,
  parameter logic [7:0] DEV_ID = 8'hD8
) (
  input  mode_t             mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        id_byte
);

  logic upper_zero;
  assign upper_zero = (rd_addr[ADDR_W-1:1] == '0);

  always_comb begin
    if (mode == MD_ID && upper_zero) id_byte = rd_addr[0] ? DEV_ID : MFR_ID;
    else                             id_byte = 8'h00;
  end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_cmd_seq_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int SECT_LSB = 12,
  parameter int BLK_LSB  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              op_start,
  output logic [1:0]        op_type,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic [1:0]        rd_mode,
  output logic [7:0]        id_byte
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  wr_dec_t    dec;
  logic       go;
  op_t        go_type;
  mode_t      mode;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  nor_cmd_decode u_dec (
    .addr_lo (wr_addr[CMP_W-1:0]),
    .data    (wr_data),
    .dec     (dec)
  );

  nor_cmd_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_valid (wr_valid),
    .busy     (busy),
    .dec      (dec),
    .go       (go),
    .go_type  (go_type),
    .mode     (mode)
  );

  nor_cmd_oplatch #(
    .ADDR_W   (ADDR_W),
    .SECT_LSB (SECT_LSB),
    .BLK_LSB  (BLK_LSB)
  ) u_lat (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .go       (go),
    .go_type  (go_type),
    .addr     (wr_addr),
    .data     (wr_data),
    .op_start (op_start),
    .op_type  (op_type),
    .op_addr  (op_addr),
    .op_data  (op_data)
  );

  nor_cmd_idmux #(
    .ADDR_W (ADDR_W)
  ) u_id (
    .mode    (mode),
    .rd_addr (rd_addr),
    .id_byte (id_byte)
  );

  assign rd_mode = mode;

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int ADDR_W   = 20,
  parameter int SECT_LSB = 12,
  parameter int BLK_LSB  = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_valid,
  input logic              busy,
  input logic              op_start,
  input logic [1:0]        op_type,
  input logic [ADDR_W-1:0] op_addr,
  input logic [7:0]        op_data,
  input logic [1:0]        rd_mode
);

  // R12: launch is a single-cycle pulse
  p_start_pulse_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_start |=> !op_start);

  // R12: operation outputs hold between launches
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_start |-> ($stable(op_addr) && $stable(op_data) && $stable(op_type)));

  // R2: a launch is caused by an accepted write
  p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_start |-> ($past(wr_valid) && !$past(busy)));

  // R11: writes under busy change nothing
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_valid && busy) |=> (!op_start && $stable(rd_mode)));

  // R8: mode encoding stays legal
  p_mode_legal_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_mode != 2'd3);

  // R9: mode moves only on an accepted write
  p_mode_cause_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(rd_mode) |-> ($past(wr_valid) && !$past(busy)));

  // R9: nothing launches outside array mode
  p_no_launch_in_id_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_mode != 2'd0) |-> !op_start);

  // R3: chip erase target
  p_chip_zero_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_start && op_type == 2'd3) |-> (op_addr == '0 && op_data == 8'hFF));

  // R4: sector erase alignment
  p_sector_align_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_start && op_type == 2'd1) |-> (op_addr[SECT_LSB-1:0] == '0));

  // R5: block erase alignment
  p_block_align_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_start && op_type == 2'd2) |-> (op_addr[BLK_LSB-1:0] == '0));

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(
  .ADDR_W   (ADDR_W),
  .SECT_LSB (SECT_LSB),
  .BLK_LSB  (BLK_LSB)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_valid   (wr_valid),
  .busy       (busy),
  .op_start   (op_start),
  .op_type    (op_type),
  .op_addr    (op_addr),
  .op_data    (op_data),
  .rd_mode    (rd_mode)
);

// File: tb/nor_cmd_seq_bench.sv
`timescale 1ns/1ps
module nor_cmd_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 20;
  localparam int WD_CYCLES  = 150000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          busy;
  logic [AW-1:0] rd_addr;
  logic          op_start;
  logic [1:0]    op_type;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data;
  logic [1:0]    rd_mode;
  logic [7:0]    id_byte;

  int total = 0;
  int bad   = 0;

  // reference model state
  int            m_seq  = 0;
  int            m_mode = 0;
  logic          e_start;
  logic [1:0]    e_type = '0;
  logic [AW-1:0] e_addr = '0;
  logic [7:0]    e_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_seq u_nor_cmd_seq (
    .clk (clk), .rst_n (rst_n), .wr_valid (wr_valid), .wr_addr (wr_addr),
    .wr_data (wr_data), .busy (busy), .rd_addr (rd_addr),
    .op_start (op_start), .op_type (op_type), .op_addr (op_addr),
    .op_data (op_data), .rd_mode (rd_mode), .id_byte (id_byte)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [1:0] t, input logic [AW-1:0] a, input logic [7:0] d);
    e_start = 1'b1; e_type = t; e_addr = a; e_data = d;
  endtask

  task automatic model(input logic [AW-1:0] a, input logic [7:0] d, input logic bz);
    logic lo, hi;
    lo = (a[14:0] == 15'h5555);
    hi = (a[14:0] == 15'h2AAA);
    e_start = 1'b0;
    if (bz) return;
    case (m_seq)
      0: if (m_mode != 0 && d == 8'hF0) m_mode = 0;
         else if (lo && d == 8'hAA) m_seq = 1;
      1: m_seq = (hi && d == 8'h55) ? 2 : 0;
      2: begin
        m_seq = 0;
        if (m_mode == 0 && lo) begin
          if (d == 8'hA0) m_seq = 3;
          else if (d == 8'h80) m_seq = 4;
          else if (d == 8'h90) m_mode = 1;
          else if (d == 8'h98) m_mode = 2;
        end else if (m_mode != 0 && lo && d == 8'hF0) m_mode = 0;
      end
      3: begin m_seq = 0; launch(2'd0, a, d); end
      4: m_seq = (lo && d == 8'hAA) ? 5 : 0;
      5: m_seq = (hi && d == 8'h55) ? 6 : 0;
      6: begin
        m_seq = 0;
        if (lo && d == 8'h10)  launch(2'd3, '0, 8'hFF);
        else if (d == 8'h30)   launch(2'd1, {a[19:12], 12'h0}, 8'hFF);
        else if (d == 8'h50)   launch(2'd2, {a[19:16], 16'h0}, 8'hFF);
      end
      default: m_seq = 0;
    endcase
  endtask

  task automatic wr(input string tag, input logic [AW-1:0] a, input logic [7:0] d,
                    input logic bz = 1'b0);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; busy = bz;
    model(a, d, bz);
    @(negedge clk);
    wr_valid = 1'b0; busy = 1'b0;
    chk({tag, " start"}, {31'd0, op_start}, {31'd0, e_start});
    chk({tag, " mode"},  {30'd0, rd_mode},  m_mode);
    chk({tag, " type"},  {30'd0, op_type},  {30'd0, e_type});
    chk({tag, " addr"},  {12'd0, op_addr},  {12'd0, e_addr});
    chk({tag, " data"},  {24'd0, op_data},  {24'd0, e_data});
  endtask

  task automatic unlock(input string tag, input logic [AW-1:0] hi_bits = '0);
    wr(tag, hi_bits | 20'h05555, 8'hAA);
    wr(tag, hi_bits | 20'h02AAA, 8'h55);
  endtask

  task automatic id_rd(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
    @(negedge clk);
    rd_addr = a;
    #1;
    chk(tag, {24'd0, id_byte}, {24'd0, exp});
  endtask

  // scripted sequence with optional corruption
  task automatic rnd_seq(input int kind, input int corrupt_pct);
    logic [AW-1:0] sa [6];
    logic [7:0]    sd [6];
    int n;
    logic [AW-1:0] up;
    up = AW'($urandom) & 20'hF8000;
    sa[0] = up | 20'h05555; sd[0] = 8'hAA;
    sa[1] = up | 20'h02AAA; sd[1] = 8'h55;
    sa[2] = up | 20'h05555;
    sa[3] = up | 20'h05555; sd[3] = 8'hAA;
    sa[4] = up | 20'h02AAA; sd[4] = 8'h55;
    sa[5] = AW'($urandom);  sd[5] = 8'h30;
    n = 3;
    case (kind)
      0: begin sd[2] = 8'hA0; sa[3] = AW'($urandom); sd[3] = 8'($urandom); n = 4; end
      1: begin sd[2] = 8'h80; sa[5] = up | 20'h05555; sd[5] = 8'h10; n = 6; end
      2: begin sd[2] = 8'h80; sd[5] = 8'h30; n = 6; end
      3: begin sd[2] = 8'h80; sd[5] = 8'h50; n = 6; end
      4: sd[2] = 8'h90;
      5: sd[2] = 8'h98;
      default: sd[2] = 8'hF0;
    endcase
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      logic bz;
      a = sa[i]; d = sd[i];
      if (int'($urandom_range(99)) < corrupt_pct) begin
        if ($urandom_range(1) == 0) d = 8'($urandom);
        else a[14:0] = 15'($urandom);
      end
      bz = ($urandom_range(99) < 8);
      wr("R10 random", a, d, bz);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; busy = 1'b0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 start", {31'd0, op_start}, 0);
    chk("R1 mode",  {30'd0, rd_mode},  0);
    chk("R1 type",  {30'd0, op_type},  0);
    chk("R1 addr",  {12'd0, op_addr},  0);
    chk("R1 data",  {24'd0, op_data},  0);

    // R2 program
    unlock("R2"); wr("R2", 20'h05555, 8'hA0); wr("R2 launch", 20'h91234, 8'h5A);
    wr("R12 hold", 20'h00000, 8'h00);

    // R6 upper address bits ignored / bit 14 matters
    unlock("R6", 20'hA8000); wr("R6", 20'hD5555, 8'hA0); wr("R6 launch", 20'h00042, 8'hC3);
    wr("R6", 20'h01555, 8'hAA); wr("R6", 20'h02AAA, 8'h55);
    wr("R6", 20'h05555, 8'hA0); wr("R6 nolaunch", 20'h00077, 8'h11);

    // R3 chip, R4 sector, R5 block
    unlock("R3"); wr("R3", 20'h05555, 8'h80); unlock("R3"); wr("R3 launch", 20'h05555, 8'h10);
    unlock("R4"); wr("R4", 20'h05555, 8'h80); unlock("R4"); wr("R4 launch", 20'hABCDE, 8'h30);
    unlock("R5"); wr("R5", 20'h05555, 8'h80); unlock("R5"); wr("R5 launch", 20'h71234, 8'h50);

    // R7 identification
    unlock("R7"); wr("R7 enter", 20'h05555, 8'h90);
    id_rd("R7 mfr", 20'h00000, 8'hBF);
    id_rd("R7 dev", 20'h00001, 8'hD8);
    id_rd("R7 other", 20'h00002, 8'h00);
    id_rd("R7 high", 20'h80000, 8'h00);
    // R9 other commands ignored in identification mode
    unlock("R9"); wr("R9", 20'h05555, 8'hA0); wr("R9 ignored", 20'h00100, 8'h22);
    // R11 exit under busy ignored
    wr("R11 busy exit", 20'h12345, 8'hF0, 1'b1);
    wr("R9 exit", 20'h12345, 8'hF0);
    id_rd("R7 array", 20'h00000, 8'h00);

    // R8 query and unlocked exit
    unlock("R8"); wr("R8 enter", 20'h05555, 8'h98);
    unlock("R9"); wr("R9 exit2", 20'h05555, 8'hF0);

    // R10 broken sequences
    unlock("R10"); wr("R10", 20'h02AAA, 8'h55); wr("R10", 20'h05555, 8'hA0);
    wr("R10 nolaunch", 20'h00300, 8'h33);
    unlock("R10"); wr("R10", 20'h05555, 8'h80); wr("R10", 20'h05555, 8'hAA);
    wr("R10", 20'h02AAA, 8'h12); wr("R10 nolaunch", 20'h05555, 8'h10);
    unlock("R10"); wr("R10", 20'h05555, 8'hA0); wr("R10 fresh", 20'h00400, 8'h44);

    // R11 busy during program: progress kept across ignored writes
    wr("R11", 20'h05555, 8'hAA);
    wr("R11 busy", 20'h33333, 8'h99, 1'b1);
    wr("R11", 20'h02AAA, 8'h55);
    wr("R11", 20'h05555, 8'hA0);
    wr("R11 busy data", 20'h00500, 8'h55, 1'b1);
    wr("R11 launch", 20'h00600, 8'h66);

    // constrained random
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(4) == 0)
        wr("R10 noise", ($urandom_range(1) == 0) ? 20'h05555 : AW'($urandom),
           ($urandom_range(1) == 0) ? 8'hF0 : 8'($urandom), $urandom_range(9) == 0);
      else
        rnd_seq(int'($urandom_range(6)), 12);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule